// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital sequencer behind an on-die supply supervisor. Two analog comparators report when the supply has dropped below a warning level and when it has dropped below the level at which the core can no longer run. Both levels are sampled through a synchronizer. From them the block produces the core's internal reset, a power-fail interrupt request and two sticky status flags. A 2-bit write port lets software clear the flags.

After a brownout, or after the first power-up, reset stays asserted for a fixed stabilization window of oscillator cycles once the supply is good again. When the window ends, the block releases the core with a one-cycle boot strobe that carries the start address. In stop mode the comparators can be switched off to save power. A keep-alive bit keeps them running in their reduced-power mode instead. While they are off, the block disregards whatever they report.

Top module: `supply_guard`

## Requirements
- R1: Each comparator input is re-timed by a two-stage synchronizer. A level applied before a rising edge reaches `sys_rst_o` after the second rising edge, and reaches the status flag after the third.
- R2: When the synchronized warning input is high, status bit 0 (power-fail) is set. Hardware never clears it.
- R3: With `stat_wr_i` high, a 0 in `stat_wdata_i` bit 0 clears power-fail and a 0 in bit 1 clears power-on. A 1 leaves the bit unchanged. A set event in the same cycle as a clear leaves the bit set.
- R4: `pf_irq_o` is high exactly when status bit 0 and `pf_ie_i` are both high. While it is high, `irq_vec_o` reads 0x0033; otherwise it reads 0.
- R5: When the synchronized reset-level input is high, `sys_rst_o` is high in that same cycle.
- R6: `sys_rst_o` falls after the (HOLD_CYCLES+2)-th rising edge that follows removal of the reset-level input, where HOLD_CYCLES defaults to 65,536. Two of those edges come from the synchronizer.
- R7: In the first cycle after `sys_rst_o` falls, `boot_o` is high for one cycle and `boot_addr_o` reads 0x0000. At all other times both read 0.
- R8: While `cold_rst_ni` is low, `sys_rst_o` is 1, status reads 2'b10 (power-on set, power-fail clear) and `boot_o` is 0. A later brownout does not set power-on again.
- R9: With `stop_mode_i`=1 and `keep_alive_i`=0, `mon_en_o` is 0 and both comparator inputs are ignored: no reset and no power-fail flag.
- R10: With `stop_mode_i`=1 and `keep_alive_i`=1, `mon_en_o` is 1 and both inputs act as in run mode.
- R11: If the reset-level input returns while the stabilization count is running, the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| cold_rst_ni | input | 1 | Asynchronous active-low cold-start (initial power-up) |
| below_warn_i | input | 1 | Comparator: supply below warning level (asynchronous) |
| below_rst_i | input | 1 | Comparator: supply below reset level (asynchronous) |
| stop_mode_i | input | 1 | Device is in stop mode |
| keep_alive_i | input | 1 | Keep comparators powered in stop mode |
| pf_ie_i | input | 1 | Power-fail interrupt enable |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Status write data: bit 0 power-fail, bit 1 power-on |
| sys_rst_o | output | 1 | Internal core reset, active high |
| mon_en_o | output | 1 | Comparator power enable |
| pf_irq_o | output | 1 | Power-fail interrupt request |
| irq_vec_o | output | 16 | Interrupt vector address while requesting |
| boot_o | output | 1 | One-cycle strobe at reset release |
| boot_addr_o | output | 16 | Start fetch address during the strobe |
| stat_o | output | 2 | Status flags: bit 0 power-fail, bit 1 power-on |

## Verification
The assertions take it for granted that the comparator inputs stay at one level for at least two clock cycles, so that the synchronizer's latency is the only delay between a level change and its effect. The bench changes each input only on a falling edge and holds it for several cycles. It switches stop mode off only after the comparator inputs have returned low and the synchronizer has drained, so stale levels never reach the core.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
   localparam int unsigned STAT_W  = 2;
   localparam int unsigned PF_BIT  = 0;
   localparam int unsigned POR_BIT = 1;
   localparam int unsigned CMP_W   = 2;

   typedef struct packed {
      logic warn;
      logic brown;
   } cmp_t;

   typedef enum logic {
      MON_OFF = 1'b0,
      MON_ON  = 1'b1
   } mon_state_e;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      stages_cfg_chk: assert (STAGES >= 2) else $error("sg_sync needs at least two stages");
      width_cfg_chk: assert (WIDTH >= 1) else $error("sg_sync width must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sg_hold_timer.sv
module sg_hold_timer #(
   parameter int unsigned HOLD_CYCLES = 65536
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic brown_i,
   output logic hold_o
);
   localparam int unsigned CNT_W = $clog2(HOLD_CYCLES) + 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(HOLD_CYCLES - 1);

   initial begin
      hold_cfg_chk: assert (HOLD_CYCLES >= 2) else $error("hold window too short");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         hold_q <= 1'b1;
      end else if (brown_i) begin
         cnt_q  <= '0;
         hold_q <= 1'b1;
      end else if (hold_q) begin
         if (cnt_q == TERM) hold_q <= 1'b0;
         else               cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign hold_o = hold_q;

   // R6
   release_at_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(hold_q) |-> $past(cnt_q) == TERM);

   // R11
   restart_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brown_i |=> (hold_q && cnt_q == '0));
endmodule

// File: rtl/sg_flags.sv
module sg_flags #(
   parameter int unsigned            NFLAG   = 2,
   parameter logic [NFLAG-1:0]       RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NFLAG-1:0] set_i,
   input  logic             wr_i,
   input  logic [NFLAG-1:0] wdata_i,
   output logic [NFLAG-1:0] flags_o
);
   logic [NFLAG-1:0] flags_q;
   logic [NFLAG-1:0] clr;
   logic [NFLAG-1:0] nxt;

   for (genvar b = 0; b < NFLAG; b++) begin : g_flag
      assign clr[b] = wr_i & ~wdata_i[b];
      assign nxt[b] = set_i[b] | (flags_q[b] & ~clr[b]);

      // R2
      set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[b] |=> flags_q[b]);

      // R3
      sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flags_q[b] && !(wr_i && !wdata_i[b])) |=> flags_q[b]);

      // R8
      no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!flags_q[b] && !set_i[b]) |=> !flags_q[b]);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= RST_VAL;
      else         flags_q <= nxt;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
   parameter int unsigned HOLD_CYCLES = 65536,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [15:0] BOOT_ADDR   = 16'h0000,
   parameter logic [15:0] PF_VECTOR   = 16'h0033
) (
   input  logic              clk_i,
   input  logic              cold_rst_ni,
   input  logic              below_warn_i,
   input  logic              below_rst_i,
   input  logic              stop_mode_i,
   input  logic              keep_alive_i,
   input  logic              pf_ie_i,
   input  logic              stat_wr_i,
   input  logic [1:0]        stat_wdata_i,
   output logic              sys_rst_o,
   output logic              mon_en_o,
   output logic              pf_irq_o,
   output logic [ADDR_W-1:0] irq_vec_o,
   output logic              boot_o,
   output logic [ADDR_W-1:0] boot_addr_o,
   output logic [1:0]        stat_o
);
   import supply_guard_pkg::*;

   initial begin
      addr_cfg_chk: assert (ADDR_W >= 8 && ADDR_W <= 16) else $error("address width out of range");
   end

   cmp_t             raw_cmp, sync_cmp, live_cmp;
   mon_state_e       mon_state;
   logic             hold;
   logic             rst_seen_q;
   logic [STAT_W-1:0] set_vec;

   assign mon_state = (!stop_mode_i || keep_alive_i) ? MON_ON : MON_OFF;
   assign mon_en_o  = (mon_state == MON_ON);

   assign raw_cmp.warn  = below_warn_i;
   assign raw_cmp.brown = below_rst_i;

   sg_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk_i  (clk_i),
      .rst_ni (cold_rst_ni),
      .d_i    (raw_cmp),
      .q_o    (sync_cmp)
   );

   assign live_cmp = mon_en_o ? sync_cmp : '0;

   sg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) timer_i (
      .clk_i   (clk_i),
      .rst_ni  (cold_rst_ni),
      .brown_i (live_cmp.brown),
      .hold_o  (hold)
   );

   assign set_vec[PF_BIT]  = live_cmp.warn;
   assign set_vec[POR_BIT] = 1'b0;

   sg_flags #(.NFLAG(STAT_W), .RST_VAL(STAT_W'(1) << POR_BIT)) flags_i (
      .clk_i   (clk_i),
      .rst_ni  (cold_rst_ni),
      .set_i   (set_vec),
      .wr_i    (stat_wr_i),
      .wdata_i (stat_wdata_i),
      .flags_o (stat_o)
   );

   assign sys_rst_o = hold | live_cmp.brown;

   always_ff @(posedge clk_i or negedge cold_rst_ni) begin
      if (!cold_rst_ni) rst_seen_q <= 1'b1;
      else              rst_seen_q <= sys_rst_o;
   end

   assign boot_o      = rst_seen_q & ~sys_rst_o;
   assign boot_addr_o = boot_o ? BOOT_ADDR[ADDR_W-1:0] : '0;
   assign pf_irq_o    = stat_o[PF_BIT] & pf_ie_i;
   assign irq_vec_o   = pf_irq_o ? PF_VECTOR[ADDR_W-1:0] : '0;

   // R9
   gated_no_reset_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
      (!mon_en_o && !$past(sys_rst_o)) |-> !sys_rst_o);

   // R7
   boot_single_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
      boot_o |=> !boot_o);

   // R5
   brown_hold_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
      live_cmp.brown |=> hold);
endmodule

// File: tb/supply_guard_tb.sv
module supply_guard_tb_top;
   localparam int unsigned H = 65536;

   logic        clk = 1'b0;
   logic        cold_rst_n, warn, brown, stop, keep, ie, wr;
   logic [1:0]  wd;
   logic        sys_rst, mon_en, irq, boot;
   logic [15:0] ivec, baddr;
   logic [1:0]  stat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   supply_guard dut_i (
      .clk_i(clk), .cold_rst_ni(cold_rst_n), .below_warn_i(warn), .below_rst_i(brown),
      .stop_mode_i(stop), .keep_alive_i(keep), .pf_ie_i(ie), .stat_wr_i(wr),
      .stat_wdata_i(wd), .sys_rst_o(sys_rst), .mon_en_o(mon_en), .pf_irq_o(irq),
      .irq_vec_o(ivec), .boot_o(boot), .boot_addr_o(baddr), .stat_o(stat)
   );

   // [7] warn, [6] write, [5:4] write data, [3] irq enable,
   // [2] expected power-fail, [1] expected irq, [0] expected power-on
   localparam logic [7:0] VEC [8] = '{
      8'b1_0_00_0_101,
      8'b0_0_00_1_111,
      8'b0_1_11_1_111,
      8'b0_1_10_1_001,
      8'b1_1_10_1_111,
      8'b0_1_01_0_100,
      8'b0_1_00_0_000,
      8'b0_0_00_1_000
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cold_rst_n = 1'b0; warn = 1'b1; brown = 1'b1; stop = 1'b0; keep = 1'b0;
      ie = 1'b0; wr = 1'b0; wd = 2'b11;
      tick(3);
      // R8 reset state
      check("R8 sys_rst in cold reset", 32'(sys_rst), 32'd1);
      check("R8 status in cold reset", 32'(stat), 32'h2);
      check("R8 boot in cold reset", 32'(boot), 32'd0);
      cold_rst_n = 1'b1;
      tick(2);
      // R1 flag not yet set after two edges
      check("R1 flag latency", 32'(stat[0]), 32'd0);
      tick(1);
      check("R2 power-fail set", 32'(stat), 32'h3);
      wr = 1'b1; wd = 2'b10;
      tick(1);
      check("R3 set beats clear", 32'(stat[0]), 32'd1);
      wr = 1'b0;
      warn = 1'b0; brown = 1'b0;
      tick(4);
      check("R2 flag sticky", 32'(stat[0]), 32'd1);
      tick(H - 3);
      check("R6 still held before window end", 32'(sys_rst), 32'd1);
      check("R7 no boot before release", 32'(boot), 32'd0);
      tick(1);
      check("R6 released", 32'(sys_rst), 32'd0);
      check("R7 boot strobe", 32'(boot), 32'd1);
      check("R7 boot address", 32'(baddr), 32'h0000);
      tick(1);
      check("R7 strobe one cycle", 32'(boot), 32'd0);

      // R2 R3 R4 vector table
      foreach (VEC[i]) begin
         warn = VEC[i][7]; wr = VEC[i][6]; wd = VEC[i][5:4]; ie = VEC[i][3];
         tick(4);
         check($sformatf("R3 vec%0d power-fail", i), 32'(stat[0]), 32'(VEC[i][2]));
         check($sformatf("R4 vec%0d irq", i), 32'(irq), 32'(VEC[i][1]));
         check($sformatf("R4 vec%0d vector", i), 32'(ivec), VEC[i][1] ? 32'h33 : 32'h0);
         check($sformatf("R3 vec%0d power-on", i), 32'(stat[1]), 32'(VEC[i][0]));
      end
      wr = 1'b0; ie = 1'b0;

      // R9 monitors off in stop mode
      stop = 1'b1; keep = 1'b0;
      tick(1);
      check("R9 mon_en off", 32'(mon_en), 32'd0);
      brown = 1'b1; warn = 1'b1;
      tick(4);
      check("R9 reset ignored", 32'(sys_rst), 32'd0);
      check("R9 flag ignored", 32'(stat), 32'h0);
      brown = 1'b0; warn = 1'b0;
      tick(3);
      stop = 1'b0;
      tick(2);
      check("R9 no reset after leaving stop", 32'(sys_rst), 32'd0);

      // R10 keep-alive in stop mode
      stop = 1'b1; keep = 1'b1;
      tick(1);
      check("R10 mon_en on", 32'(mon_en), 32'd1);
      warn = 1'b1;
      tick(3);
      check("R10 flag set in stop", 32'(stat[0]), 32'd1);
      warn = 1'b0; wr = 1'b1; wd = 2'b10;
      tick(3);
      wr = 1'b0;
      check("R3 cleared", 32'(stat[0]), 32'd0);
      brown = 1'b1;
      tick(1);
      check("R1 reset latency", 32'(sys_rst), 32'd0);
      tick(1);
      check("R5 reset asserted", 32'(sys_rst), 32'd1);

      // R11 restart during count
      brown = 1'b0;
      tick(1002);
      check("R11 counting", 32'(sys_rst), 32'd1);
      brown = 1'b1;
      tick(5);
      check("R5 reset during dip", 32'(sys_rst), 32'd1);
      brown = 1'b0;
      tick(H + 1);
      check("R11 full window after restart", 32'(sys_rst), 32'd1);
      tick(1);
      check("R6 released after brownout", 32'(sys_rst), 32'd0);
      check("R8 power-on not set by brownout", 32'(stat[1]), 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule